// File: doc/BRIEF.md
# Power-Up Reset Delay Sequencer

This block keeps a device in reset after power-on until the supply and the primary clock can be trusted. It sequences up to three fixed waits, in order: a power-up timer, an oscillator start-up count and a PLL lock wait. Which of these run depends on a configuration bit and on the primary oscillator mode. A short settling delay runs alongside the others from the moment reset lifts. The block raises a registered release output once every delay that applies has finished.

The fixed delays are counted on a free-running slow timebase clock. The start-up count is taken on the raw oscillator clock. A request to start counting crosses from the timebase domain into the oscillator domain, and the done flag crosses back, each through a two-flop synchronizer. Status flags show which phase is active. Every new power-on reset pulse starts the whole sequence again from its first phase.

Top module: `pwrup_rst_seq`

## Requirements
- R1: While `por_n` is low, `rst_release` is 0 and `ph_timer` is 1. Both stay this way until the sequence advances.
- R2: When `cfg_timer_skip` is 0, the power-up timer runs for PWRT_TICKS timebase cycles after reset lifts, and release waits for it. When `cfg_timer_skip` is 1, the timer phase ends within three timebase cycles.
- R3: In the crystal modes (`osc_mode` 0 low-power, 1 standard, 2 high-speed), the oscillator phase follows the timer phase. It lasts until OST_EDGES rising edges of `osc_clk` have been counted.
- R4: In mode 3 (high-speed with PLL), a lock wait of PLL_TICKS timebase cycles follows the completed oscillator count. `ph_lock` is high only in this mode.
- R5: In modes 4 (external clock), 5 (RC), 6 and 7 (internal), the oscillator count and the lock wait are skipped, and `ph_osc` and `ph_lock` never rise.
- R6: The short settling delay of CSD_TICKS timebase cycles starts when reset lifts and runs in parallel with the other phases. Release never comes before it has finished.
- R7: A new low pulse on `por_n` at any point, including in the middle of the oscillator count, drops `rst_release` and restarts every counter from zero.
- R8: `rst_release` is a register output. Once it is 1, it stays 1 until the next power-on reset.
- R9: At most one of `ph_timer`, `ph_osc`, `ph_lock` and `rst_release` is 1 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tb_clk | input | 1 | Free-running slow timebase clock that counts the fixed delays |
| por_n | input | 1 | Power-on reset, active low. Asserts asynchronously; its release is synchronized |
| cfg_timer_skip | input | 1 | Configuration bit: 0 enables the power-up timer, 1 skips it |
| osc_mode | input | 3 | Primary oscillator mode code: 0 LP crystal, 1 XT crystal, 2 HS crystal, 3 HS+PLL, 4 external, 5 RC, 6/7 internal |
| osc_clk | input | 1 | Raw primary oscillator clock used for the start-up count |
| rst_release | output | 1 | Registered release: 1 when all applicable delays are complete |
| ph_timer | output | 1 | Power-up timer phase active |
| ph_osc | output | 1 | Oscillator start-up count phase active |
| ph_lock | output | 1 | PLL lock wait phase active |

## Verification
The power-up timer and the parallel settling delay can expire on the same timebase edge. The bench sets both to the same length and runs an external-clock reset with the timer enabled. This makes the two done conditions arrive together. The bench then checks that release rises once, inside the expected window, and stays high. A second collision is a fresh power-on pulse that lands while the oscillator count is in flight. That run is judged by release dropping at once, the timer flag returning, and the full crystal delay being measured again from the new pulse.

// File: rtl/prs_pkg.sv
package prs_pkg;

  localparam logic [2:0] MODE_LP    = 3'd0;
  localparam logic [2:0] MODE_XT    = 3'd1;
  localparam logic [2:0] MODE_HS    = 3'd2;
  localparam logic [2:0] MODE_HSPLL = 3'd3;
  localparam logic [2:0] MODE_EXT   = 3'd4;
  localparam logic [2:0] MODE_RC    = 3'd5;
  localparam logic [2:0] MODE_INT   = 3'd6;

  typedef enum logic [2:0] {
    ST_TIMER = 3'd0,
    ST_OSC   = 3'd1,
    ST_LOCK  = 3'd2,
    ST_TAIL  = 3'd3,
    ST_DONE  = 3'd4
  } seq_state_e;

  function automatic logic mode_uses_ost(input logic [2:0] m);
    return (m <= MODE_HSPLL);
  endfunction

  function automatic logic mode_uses_pll(input logic [2:0] m);
    return (m == MODE_HSPLL);
  endfunction

endpackage

// File: rtl/prs_rst_sync.sv
module prs_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_o = stage_q[1];
endmodule

// File: rtl/prs_sync2.sv
module prs_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [1:0] ff_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff_q <= 2'b00;
    else        ff_q <= {ff_q[0], d};
  end

  assign q = ff_q[1];
endmodule

// File: rtl/prs_tick_timer.sv
module prs_tick_timer #(
  parameter int TICKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int W = $clog2(TICKS + 1);
  localparam logic [W-1:0] LIMIT = W'(TICKS);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign done   = (cnt_q == LIMIT);
  assign cnt_en = run && !done;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R6: count never passes its limit
  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT);

  // R8: completion holds until the next reset
  p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
endmodule

// File: rtl/prs_osc_count.sv
module prs_osc_count #(
  parameter int EDGES = 1024
) (
  input  logic osc_clk,
  input  logic por_n,
  input  logic go_tb,
  output logic done_o
);
  localparam int W = $clog2(EDGES + 1);
  localparam logic [W-1:0] LIMIT = W'(EDGES);

  logic         osc_rst_n;
  logic         go_s;
  logic [W-1:0] cnt_q, cnt_d;

  prs_rst_sync u_rs (.clk(osc_clk), .arst_n(por_n), .rst_n_o(osc_rst_n));
  prs_sync2    u_go (.clk(osc_clk), .rst_n(osc_rst_n), .d(go_tb), .q(go_s));

  assign done_o = (cnt_q == LIMIT);

  always_comb begin
    cnt_d = cnt_q;
    if (go_s && !done_o) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge osc_clk or negedge osc_rst_n) begin
    if (!osc_rst_n) cnt_q <= '0;
    else            cnt_q <= cnt_d;
  end

  // R3: edge count stops exactly at its limit
  p_ost_bound_r3: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
    cnt_q <= LIMIT);

  // R3: counting only advances once requested
  p_ost_needs_go_r3: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
    (cnt_q != $past(cnt_q)) |-> $past(go_s));
endmodule

// File: rtl/pwrup_rst_seq.sv
module pwrup_rst_seq #(
  parameter int PWRT_TICKS = 2048,
  parameter int CSD_TICKS  = 4,
  parameter int PLL_TICKS  = 64,
  parameter int OST_EDGES  = 1024
) (
  input  logic       tb_clk,
  input  logic       por_n,
  input  logic       cfg_timer_skip,
  input  logic [2:0] osc_mode,
  input  logic       osc_clk,
  output logic       rst_release,
  output logic       ph_timer,
  output logic       ph_osc,
  output logic       ph_lock
);
  import prs_pkg::*;

  logic       rst_tb_n;
  logic       ptmr_done, csd_done, pll_done;
  logic       ost_done_osc, ost_done_tb;
  logic       timer_ok;
  logic       ost_go_q, ost_go_d;
  logic       rel_q, rel_d;
  seq_state_e state_q, state_d;

  prs_rst_sync u_rst (.clk(tb_clk), .arst_n(por_n), .rst_n_o(rst_tb_n));

  generate
    if (PWRT_TICKS > 0) begin : g_ptmr
      prs_tick_timer #(.TICKS(PWRT_TICKS)) u_ptmr (
        .clk(tb_clk), .rst_n(rst_tb_n), .run(!cfg_timer_skip), .done(ptmr_done));
    end else begin : g_no_ptmr
      assign ptmr_done = 1'b1;
    end

    if (CSD_TICKS > 0) begin : g_csd
      prs_tick_timer #(.TICKS(CSD_TICKS)) u_csd (
        .clk(tb_clk), .rst_n(rst_tb_n), .run(1'b1), .done(csd_done));
    end else begin : g_no_csd
      assign csd_done = 1'b1;
    end

    if (PLL_TICKS > 0) begin : g_pll
      prs_tick_timer #(.TICKS(PLL_TICKS)) u_pll (
        .clk(tb_clk), .rst_n(rst_tb_n), .run(state_q == ST_LOCK), .done(pll_done));
    end else begin : g_no_pll
      assign pll_done = 1'b1;
    end
  endgenerate

  prs_osc_count #(.EDGES(OST_EDGES)) u_ost (
    .osc_clk(osc_clk), .por_n(por_n), .go_tb(ost_go_q), .done_o(ost_done_osc));

  prs_sync2 u_ost_back (.clk(tb_clk), .rst_n(rst_tb_n), .d(ost_done_osc), .q(ost_done_tb));

  assign timer_ok = cfg_timer_skip || ptmr_done;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_TIMER: if (timer_ok)    state_d = mode_uses_ost(osc_mode) ? ST_OSC : ST_TAIL;
      ST_OSC:   if (ost_done_tb) state_d = mode_uses_pll(osc_mode) ? ST_LOCK : ST_TAIL;
      ST_LOCK:  if (pll_done)    state_d = ST_TAIL;
      ST_TAIL:  if (csd_done)    state_d = ST_DONE;
      ST_DONE:                   state_d = ST_DONE;
      default:                   state_d = ST_TIMER;
    endcase
    ost_go_d = (state_d == ST_OSC);
    rel_d    = (state_d == ST_DONE);
  end

  always_ff @(posedge tb_clk or negedge rst_tb_n) begin
    if (!rst_tb_n) begin
      state_q  <= ST_TIMER;
      ost_go_q <= 1'b0;
      rel_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      ost_go_q <= ost_go_d;
      rel_q    <= rel_d;
    end
  end

  assign rst_release = rel_q;
  assign ph_timer    = (state_q == ST_TIMER);
  assign ph_osc      = (state_q == ST_OSC);
  assign ph_lock     = (state_q == ST_LOCK);

  // R9: status flags are mutually exclusive
  p_flags_onehot_r9: assert property (@(posedge tb_clk) disable iff (!rst_tb_n)
    $onehot0({ph_timer, ph_osc, ph_lock, rst_release}));

  // R8: release holds until the next power-on reset
  p_release_sticky_r8: assert property (@(posedge tb_clk) disable iff (!rst_tb_n)
    rst_release |=> rst_release);

  // R6: release only after the parallel settling delay
  p_release_after_csd_r6: assert property (@(posedge tb_clk) disable iff (!rst_tb_n)
    rst_release |-> csd_done);

  // R2: release only after the enabled power-up timer
  p_release_after_ptmr_r2: assert property (@(posedge tb_clk) disable iff (!rst_tb_n)
    (rst_release && !cfg_timer_skip) |-> ptmr_done);

  // R4: lock wait only in the PLL mode
  p_lock_mode_r4: assert property (@(posedge tb_clk) disable iff (!rst_tb_n)
    ph_lock |-> (osc_mode == MODE_HSPLL));

  // R5: oscillator phase only in modes that count edges
  p_osc_mode_r5: assert property (@(posedge tb_clk) disable iff (!rst_tb_n)
    ph_osc |-> (osc_mode <= MODE_HSPLL));
endmodule

// File: tb/sim_pwrup_rst_seq.sv
module sim_pwrup_rst_seq;
  localparam int TB_PERIOD  = 20;
  localparam int OSC_HALF   = 1;
  localparam int PWRT       = 24;
  localparam int CSD        = 24;
  localparam int PLL        = 30;
  localparam int EDGES      = 1024;

  logic       tb_clk = 1'b0;
  logic       osc_clk = 1'b0;
  logic       por_n = 1'b0;
  logic       cfg_timer_skip = 1'b0;
  logic [2:0] osc_mode = 3'd4;
  logic       rst_release, ph_timer, ph_osc, ph_lock;

  int checks = 0;
  int errors = 0;
  logic finished = 1'b0;

  always #(TB_PERIOD/2) tb_clk = ~tb_clk;
  always #(OSC_HALF) osc_clk = ~osc_clk;

  pwrup_rst_seq #(.PWRT_TICKS(PWRT), .CSD_TICKS(CSD), .PLL_TICKS(PLL), .OST_EDGES(EDGES)) u0 (
    .tb_clk(tb_clk), .por_n(por_n), .cfg_timer_skip(cfg_timer_skip), .osc_mode(osc_mode),
    .osc_clk(osc_clk), .rst_release(rst_release), .ph_timer(ph_timer), .ph_osc(ph_osc),
    .ph_lock(ph_lock));

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_win(input int n, input int lo, input int hi, input string tag);
    checks++;
    if (n < lo || n > hi) begin
      errors++;
      $display("FAIL %s release cycle actual=%0d expected=%0d..%0d", tag, n, lo, hi);
    end
  endtask

  // Hold power-on reset, check the reset state (R1), then release at a falling edge
  task automatic apply_por(input logic [2:0] mode, input logic skip);
    @(negedge tb_clk);
    por_n = 1'b0;
    osc_mode = mode;
    cfg_timer_skip = skip;
    repeat (3) @(negedge tb_clk);
    check(rst_release == 1'b0, "R1 release low in reset", int'(rst_release), 0);
    check(ph_timer == 1'b1, "R1 timer flag in reset", int'(ph_timer), 1);
    por_n = 1'b1;
  endtask

  task automatic wait_release(output int n, output logic saw_osc, output logic saw_lock,
                              output logic tmr10, output logic multi);
    n = 0; saw_osc = 0; saw_lock = 0; tmr10 = 0; multi = 0;
    while (!rst_release && n < 1000) begin
      @(posedge tb_clk);
      n++;
      @(negedge tb_clk);
      if (ph_osc) saw_osc = 1;
      if (ph_lock) saw_lock = 1;
      if (n == 10) tmr10 = ph_timer;
      if ((int'(ph_timer) + int'(ph_osc) + int'(ph_lock) + int'(rst_release)) > 1) multi = 1;
    end
  endtask

  task automatic t_ext_coincide;
    int n; logic so, sl, t10, mu;
    apply_por(3'd4, 1'b0);
    wait_release(n, so, sl, t10, mu);
    check_win(n, 24, 34, "R6 R2 ext timer and settle coincide");
    check(t10 == 1'b1, "R2 timer phase active when enabled", int'(t10), 1);
    check(so == 1'b0 && sl == 1'b0, "R5 ext skips osc/lock", int'(so) + int'(sl), 0);
    check(mu == 1'b0, "R9 flags exclusive", int'(mu), 0);
    repeat (20) @(negedge tb_clk);
    check(rst_release == 1'b1, "R8 release sticky", int'(rst_release), 1);
  endtask

  task automatic t_ext_skip;
    int n; logic so, sl, t10, mu;
    apply_por(3'd4, 1'b1);
    wait_release(n, so, sl, t10, mu);
    check_win(n, 24, 34, "R6 settle alone holds release");
    check(t10 == 1'b0, "R2 timer skipped", int'(t10), 0);
  endtask

  task automatic t_rc_int;
    int n; logic so, sl, t10, mu;
    apply_por(3'd5, 1'b1);
    wait_release(n, so, sl, t10, mu);
    check_win(n, 24, 34, "R5 RC mode");
    check(so == 1'b0, "R5 RC no osc phase", int'(so), 0);
    apply_por(3'd6, 1'b0);
    wait_release(n, so, sl, t10, mu);
    check_win(n, 24, 34, "R5 internal mode");
    check(so == 1'b0 && sl == 1'b0, "R5 internal no osc/lock", int'(so) + int'(sl), 0);
  endtask

  task automatic t_crystal;
    int n; logic so, sl, t10, mu;
    apply_por(3'd1, 1'b0);
    wait_release(n, so, sl, t10, mu);
    check_win(n, 126, 142, "R3 XT timer then osc count");
    check(so == 1'b1 && sl == 1'b0, "R3 XT osc phase, no lock", int'(so) * 2 + int'(sl), 2);
    check(mu == 1'b0, "R9 flags exclusive XT", int'(mu), 0);
    apply_por(3'd2, 1'b1);
    wait_release(n, so, sl, t10, mu);
    check_win(n, 102, 118, "R3 HS osc count only");
    apply_por(3'd0, 1'b1);
    wait_release(n, so, sl, t10, mu);
    check_win(n, 102, 118, "R3 LP osc count only");
  endtask

  task automatic t_pll;
    int n; logic so, sl, t10, mu;
    apply_por(3'd3, 1'b0);
    wait_release(n, so, sl, t10, mu);
    check_win(n, 156, 174, "R4 PLL adds lock wait");
    check(sl == 1'b1, "R4 lock phase seen", int'(sl), 1);
    check(mu == 1'b0, "R9 flags exclusive PLL", int'(mu), 0);
  endtask

  task automatic t_restart;
    int n; logic so, sl, t10, mu;
    apply_por(3'd1, 1'b0);
    repeat (60) @(negedge tb_clk);
    check(ph_osc == 1'b1, "R7 in osc phase before repulse", int'(ph_osc), 1);
    por_n = 1'b0;
    #1;
    check(rst_release == 1'b0 && ph_timer == 1'b1, "R7 repulse resets phase",
          int'(ph_timer), 1);
    repeat (3) @(negedge tb_clk);
    por_n = 1'b1;
    wait_release(n, so, sl, t10, mu);
    check_win(n, 126, 142, "R7 full delay after repulse");
  endtask

  initial begin
    #(TB_PERIOD * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge tb_clk);
    check(rst_release == 1'b0, "R1 release low at start", int'(rst_release), 0);
    t_ext_coincide();
    t_ext_skip();
    t_rc_int();
    t_crystal();
    t_pll();
    t_restart();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule